// File: doc/BRIEF.md
# Data Pointer Address Generator

This block forms the effective data-memory address for the load and store operations of a small 8-bit controller core. The register file outside the block presents three 16-bit pointer registers, named X, Y and Z here, together with an access request. The request carries a mode, a pointer choice, a short unsigned offset, a 16-bit address word and a page byte. One cycle later the block drives the full address and an access strobe. For the pointer-updating modes it also drives the new pointer value, a write enable and the index of the pointer to write.

Five modes are supported. Plain indirect uses the pointer as it is. Pre-decrement lowers the pointer and then uses the lowered value. Post-increment uses the old value and then raises the pointer. Offset mode adds the offset to Y or Z. Direct mode takes the 16-bit word from the second instruction word and places the page byte above it, so that data beyond 64 KB can be reached. Any request that cannot be served raises an illegal flag, and no memory access follows from it.

Top module: `dptr_agen`

## Requirements
- R1: While the synchronous active-high reset is held, and in the first cycle after it, acc_stb_o, ptr_wr_en_o and illegal_o are 0, and ea_o, ptr_wr_val_o and ptr_wr_sel_o are 0.
- R2: All results appear one clock edge after a cycle with req_i high. For mode 0 (plain), ea_o = {8'h00, pointer}, acc_stb_o = 1 and ptr_wr_en_o = 0. The pointer is selected by ptr_sel_i: 0 = X, 1 = Y, 2 = Z.
- R3: For mode 1 (pre-decrement), ea_o[15:0] = pointer - 1 and ptr_wr_val_o = pointer - 1, with ptr_wr_en_o = 1 and ptr_wr_sel_o = ptr_sel_i.
- R4: For mode 2 (post-increment), ea_o[15:0] = pointer and ptr_wr_val_o = pointer + 1, with ptr_wr_en_o = 1 and ptr_wr_sel_o = ptr_sel_i.
- R5: Pointer arithmetic wraps at 16 bits: pre-decrement of 0x0000 gives 0xFFFF, and post-increment of 0xFFFF gives 0x0000.
- R6: For mode 3 (offset), with Y or Z selected, ea_o = {8'h00, (pointer + disp_i) mod 2^16}, where disp_i is a 6-bit unsigned value from 0 to 63. ptr_wr_en_o is 0.
- R7: For mode 4 (direct), ea_o = {page_i, addr_word_i}, acc_stb_o = 1 and ptr_wr_en_o = 0. The pointer inputs have no effect.
- R8: A request is illegal if it uses mode 3 with X, if ptr_sel_i = 3, or if the mode is 5 to 7. An illegal request gives illegal_o = 1, acc_stb_o = 0, ptr_wr_en_o = 0 and ea_o = 0.
- R9: acc_stb_o, ptr_wr_en_o and illegal_o each stay high for exactly one cycle per request. After a cycle with req_i low, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request this cycle |
| mode_i | input | 3 | Addressing mode (0 plain, 1 pre-dec, 2 post-inc, 3 offset, 4 direct) |
| ptr_sel_i | input | 2 | Pointer choice (0 X, 1 Y, 2 Z) |
| ptr_x_i | input | 16 | Current X pointer |
| ptr_y_i | input | 16 | Current Y pointer |
| ptr_z_i | input | 16 | Current Z pointer |
| disp_i | input | 6 | Unsigned offset |
| addr_word_i | input | 16 | Direct address word |
| page_i | input | 8 | Page byte for direct mode |
| ea_o | output | 24 | Effective address |
| acc_stb_o | output | 1 | Memory access strobe |
| ptr_wr_val_o | output | 16 | Updated pointer value |
| ptr_wr_en_o | output | 1 | Pointer write enable |
| ptr_wr_sel_o | output | 2 | Pointer to write |
| illegal_o | output | 1 | Illegal request flag |

## Verification
The bench checks both wrap corners. A design that lets the carry escape would produce 0x1_0000 or a stray page bit instead of 0xFFFF or 0x0000. It tests pre-decrement and post-increment on the same pointer value. A design that swaps which value becomes the address would be off by one on ea_o while still writing the right pointer. It tests an offset sum that crosses 0xFFFF, which must wrap without touching the page field, and it confirms that the direct mode ignores the pointers. Finally it sends offset-with-X and the unused selector and mode codes. A design that missed these would either strobe memory or write a pointer back when it should only raise the illegal flag.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_PREDEC  = 3'd1,
    AM_POSTINC = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4
  } am_e;

  localparam int unsigned NPTR = 3;
  localparam int unsigned SELW = 2;
endpackage

// File: rtl/dptr_ptr_mux.sv
module dptr_ptr_mux
  import dptr_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0]   ptr_x,
  input  logic [AW-1:0]   ptr_y,
  input  logic [AW-1:0]   ptr_z,
  input  logic [SELW-1:0] sel,
  output logic [AW-1:0]   val,
  output logic            sel_ok
);
  logic [AW-1:0] bank [NPTR];

  assign bank[0] = ptr_x;
  assign bank[1] = ptr_y;
  assign bank[2] = ptr_z;

  always_comb begin
    val    = '0;
    sel_ok = 1'b0;
    for (int i = 0; i < int'(NPTR); i++) begin
      if (sel == SELW'(i)) begin
        val    = bank[i];
        sel_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dptr_ea_calc.sv
module dptr_ea_calc
  import dptr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 8,
  parameter int unsigned QW = 6
) (
  input  logic [2:0]      mode,
  input  logic [SELW-1:0] sel,
  input  logic            sel_ok,
  input  logic [AW-1:0]   ptr,
  input  logic [QW-1:0]   disp,
  input  logic [AW-1:0]   word,
  input  logic [PW-1:0]   page,
  output logic [PW+AW-1:0] ea,
  output logic [AW-1:0]   wr_val,
  output logic            wr_en,
  output logic            stb,
  output logic            ill
);
  localparam int unsigned EW = PW + AW;

  logic [AW-1:0] dec_v, inc_v, off_v;
  logic          is_x;

  assign dec_v = AW'(ptr - AW'(1));
  assign inc_v = AW'(ptr + AW'(1));
  assign off_v = AW'(ptr + {{(AW-QW){1'b0}}, disp});
  assign is_x  = (sel == SELW'(0));

  always_comb begin
    ea     = '0;
    wr_val = '0;
    wr_en  = 1'b0;
    stb    = 1'b0;
    ill    = 1'b0;
    case (mode)
      AM_PLAIN: begin
        if (sel_ok) begin
          ea  = {{PW{1'b0}}, ptr};
          stb = 1'b1;
        end else ill = 1'b1;
      end
      AM_PREDEC: begin
        if (sel_ok) begin
          ea     = {{PW{1'b0}}, dec_v};
          wr_val = dec_v;
          wr_en  = 1'b1;
          stb    = 1'b1;
        end else ill = 1'b1;
      end
      AM_POSTINC: begin
        if (sel_ok) begin
          ea     = {{PW{1'b0}}, ptr};
          wr_val = inc_v;
          wr_en  = 1'b1;
          stb    = 1'b1;
        end else ill = 1'b1;
      end
      AM_DISP: begin
        if (sel_ok && !is_x) begin
          ea  = {{PW{1'b0}}, off_v};
          stb = 1'b1;
        end else ill = 1'b1;
      end
      AM_DIRECT: begin
        ea  = EW'({page, word});
        stb = 1'b1;
      end
      default: ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/dptr_out_reg.sv
module dptr_out_reg
  import dptr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [PW+AW-1:0]  ea_n,
  input  logic [AW-1:0]     wr_val_n,
  input  logic              wr_en_n,
  input  logic [SELW-1:0]   wr_sel_n,
  input  logic              stb_n,
  input  logic              ill_n,
  output logic [PW+AW-1:0]  ea_q,
  output logic [AW-1:0]     wr_val_q,
  output logic              wr_en_q,
  output logic [SELW-1:0]   wr_sel_q,
  output logic              stb_q,
  output logic              ill_q
);
  always_ff @(posedge clk) begin
    if (rst || !req) begin
      ea_q     <= '0;
      wr_val_q <= '0;
      wr_en_q  <= 1'b0;
      wr_sel_q <= '0;
      stb_q    <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      ea_q     <= ea_n;
      wr_val_q <= wr_val_n;
      wr_en_q  <= wr_en_n;
      wr_sel_q <= wr_en_n ? wr_sel_n : '0;
      stb_q    <= stb_n;
      ill_q    <= ill_n;
    end
  end
endmodule

// File: rtl/dptr_agen.sv
module dptr_agen
  import dptr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 8,
  parameter int unsigned QW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [AW-1:0]     ptr_x_i,
  input  logic [AW-1:0]     ptr_y_i,
  input  logic [AW-1:0]     ptr_z_i,
  input  logic [QW-1:0]     disp_i,
  input  logic [AW-1:0]     addr_word_i,
  input  logic [PW-1:0]     page_i,
  output logic [PW+AW-1:0]  ea_o,
  output logic              acc_stb_o,
  output logic [AW-1:0]     ptr_wr_val_o,
  output logic              ptr_wr_en_o,
  output logic [1:0]        ptr_wr_sel_o,
  output logic              illegal_o
);
  localparam int unsigned EW = PW + AW;

  logic [AW-1:0] ptr_v;
  logic          sel_ok;
  logic [EW-1:0] ea_n;
  logic [AW-1:0] wr_val_n;
  logic          wr_en_n, stb_n, ill_n;

  dptr_ptr_mux #(.AW(AW)) u_mux (
    .ptr_x (ptr_x_i),
    .ptr_y (ptr_y_i),
    .ptr_z (ptr_z_i),
    .sel   (ptr_sel_i),
    .val   (ptr_v),
    .sel_ok(sel_ok)
  );

  dptr_ea_calc #(.AW(AW), .PW(PW), .QW(QW)) u_calc (
    .mode  (mode_i),
    .sel   (ptr_sel_i),
    .sel_ok(sel_ok),
    .ptr   (ptr_v),
    .disp  (disp_i),
    .word  (addr_word_i),
    .page  (page_i),
    .ea    (ea_n),
    .wr_val(wr_val_n),
    .wr_en (wr_en_n),
    .stb   (stb_n),
    .ill   (ill_n)
  );

  dptr_out_reg #(.AW(AW), .PW(PW)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .req     (req_i),
    .ea_n    (ea_n),
    .wr_val_n(wr_val_n),
    .wr_en_n (wr_en_n),
    .wr_sel_n(ptr_sel_i),
    .stb_n   (stb_n),
    .ill_n   (ill_n),
    .ea_q    (ea_o),
    .wr_val_q(ptr_wr_val_o),
    .wr_en_q (ptr_wr_en_o),
    .wr_sel_q(ptr_wr_sel_o),
    .stb_q   (acc_stb_o),
    .ill_q   (illegal_o)
  );
endmodule

// File: rtl/dptr_agen_chk.sv
module dptr_agen_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 8,
  parameter int unsigned QW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic [2:0]        mode_i,
  input logic [1:0]        ptr_sel_i,
  input logic [AW-1:0]     ptr_x_i,
  input logic [AW-1:0]     ptr_y_i,
  input logic [AW-1:0]     ptr_z_i,
  input logic [QW-1:0]     disp_i,
  input logic [AW-1:0]     addr_word_i,
  input logic [PW-1:0]     page_i,
  input logic [PW+AW-1:0]  ea_o,
  input logic              acc_stb_o,
  input logic [AW-1:0]     ptr_wr_val_o,
  input logic              ptr_wr_en_o,
  input logic [1:0]        ptr_wr_sel_o,
  input logic              illegal_o
);
  // R1: reset leaves the strobes low on the following cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!acc_stb_o && !ptr_wr_en_o && !illegal_o));

  // R2: plain mode on Y
  p_plain_y_r2: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd0 && ptr_sel_i == 2'd1) |=>
      (acc_stb_o && !ptr_wr_en_o && ea_o == {{PW{1'b0}}, $past(ptr_y_i)}));

  // R3: pre-decrement on Z
  p_predec_z_r3: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd1 && ptr_sel_i == 2'd2) |=>
      (ptr_wr_en_o && ptr_wr_sel_o == 2'd2 &&
       ptr_wr_val_o == AW'($past(ptr_z_i) - AW'(1)) &&
       ea_o[AW-1:0] == ptr_wr_val_o));

  // R4: post-increment on X
  p_postinc_x_r4: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd2 && ptr_sel_i == 2'd0) |=>
      (ptr_wr_en_o && ea_o[AW-1:0] == $past(ptr_x_i) &&
       ptr_wr_val_o == AW'($past(ptr_x_i) + AW'(1))));

  // R6: offset mode on Y
  p_disp_y_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd3 && ptr_sel_i == 2'd1) |=>
      (!ptr_wr_en_o && acc_stb_o &&
       ea_o == {{PW{1'b0}}, AW'($past(ptr_y_i) + {{(AW-QW){1'b0}}, $past(disp_i)})}));

  // R7: direct mode
  p_direct_r7: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd4) |=>
      (acc_stb_o && !ptr_wr_en_o && ea_o == {$past(page_i), $past(addr_word_i)}));

  // R8: an illegal flag never comes with an access or a write-back
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!acc_stb_o && !ptr_wr_en_o));

  // R8: offset with X is refused
  p_disp_x_r8: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd3 && ptr_sel_i == 2'd0) |=> illegal_o);

  // R9: no request, no strobes
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!acc_stb_o && !ptr_wr_en_o && !illegal_o));
endmodule

bind dptr_agen dptr_agen_chk #(.AW(AW), .PW(PW), .QW(QW)) u_chk (.*);

// File: tb/dptr_agen_bench.sv
`timescale 1ns/1ps
module dptr_agen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  ptr_sel_i = '0;
  logic [15:0] ptr_x_i = '0, ptr_y_i = '0, ptr_z_i = '0;
  logic [5:0]  disp_i = '0;
  logic [15:0] addr_word_i = '0;
  logic [7:0]  page_i = '0;
  logic [23:0] ea_o;
  logic        acc_stb_o;
  logic [15:0] ptr_wr_val_o;
  logic        ptr_wr_en_o;
  logic [1:0]  ptr_wr_sel_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dptr_agen u_dptr_agen (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive a request at the falling edge, let one rising edge register it,
  // then sample 1 ns after that edge.
  task automatic issue(input logic [2:0] m, input logic [1:0] s,
                       input logic [5:0] q, input logic [15:0] w, input logic [7:0] pg);
    @(negedge clk);
    mode_i = m; ptr_sel_i = s; disp_i = q; addr_word_i = w; page_i = pg; req_i = 1'b1;
    @(posedge clk);
    #1;
    req_i = 1'b0;
  endtask

  task automatic chk_out(input string tag, input logic [23:0] ea, input logic stb,
                         input logic wen, input logic [15:0] wv, input logic [1:0] ws,
                         input logic ill);
    chk({tag, " ea"}, 32'(ea_o), 32'(ea));
    chk({tag, " stb"}, 32'(acc_stb_o), 32'(stb));
    chk({tag, " wen"}, 32'(ptr_wr_en_o), 32'(wen));
    if (wen) begin
      chk({tag, " wval"}, 32'(ptr_wr_val_o), 32'(wv));
      chk({tag, " wsel"}, 32'(ptr_wr_sel_o), 32'(ws));
    end
    chk({tag, " ill"}, 32'(illegal_o), 32'(ill));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk_out("R1 in reset", 24'h0, 1'b0, 1'b0, 16'h0, 2'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk_out("R1 after reset", 24'h0, 1'b0, 1'b0, 16'h0, 2'd0, 1'b0);
  endtask

  task automatic t_plain;
    ptr_x_i = 16'h1234; ptr_y_i = 16'hABCD; ptr_z_i = 16'h00FF;
    issue(3'd0, 2'd0, 6'd0, 16'h0, 8'h00);
    chk_out("R2 plain X", 24'h001234, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
    issue(3'd0, 2'd1, 6'd9, 16'h5555, 8'h77);
    chk_out("R2 plain Y", 24'h00ABCD, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
    issue(3'd0, 2'd2, 6'd0, 16'h0, 8'h00);
    chk_out("R2 plain Z", 24'h0000FF, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
  endtask

  task automatic t_predec;
    ptr_x_i = 16'h0100; ptr_z_i = 16'h8000;
    issue(3'd1, 2'd0, 6'd0, 16'h0, 8'h00);
    chk_out("R3 predec X", 24'h0000FF, 1'b1, 1'b1, 16'h00FF, 2'd0, 1'b0);
    issue(3'd1, 2'd2, 6'd0, 16'h0, 8'h00);
    chk_out("R3 predec Z", 24'h007FFF, 1'b1, 1'b1, 16'h7FFF, 2'd2, 1'b0);
  endtask

  task automatic t_postinc;
    ptr_y_i = 16'h0100; ptr_x_i = 16'h00FF;
    issue(3'd2, 2'd1, 6'd0, 16'h0, 8'h00);
    chk_out("R4 postinc Y", 24'h000100, 1'b1, 1'b1, 16'h0101, 2'd1, 1'b0);
    issue(3'd2, 2'd0, 6'd0, 16'h0, 8'h00);
    chk_out("R4 postinc X", 24'h0000FF, 1'b1, 1'b1, 16'h0100, 2'd0, 1'b0);
  endtask

  task automatic t_wrap;
    ptr_y_i = 16'h0000; ptr_z_i = 16'hFFFF;
    issue(3'd1, 2'd1, 6'd0, 16'h0, 8'hFF);
    chk_out("R5 predec wrap", 24'h00FFFF, 1'b1, 1'b1, 16'hFFFF, 2'd1, 1'b0);
    issue(3'd2, 2'd2, 6'd0, 16'h0, 8'hFF);
    chk_out("R5 postinc wrap", 24'h00FFFF, 1'b1, 1'b1, 16'h0000, 2'd2, 1'b0);
  endtask

  task automatic t_disp;
    ptr_y_i = 16'h2000; ptr_z_i = 16'hFFF0;
    issue(3'd3, 2'd1, 6'd63, 16'h0, 8'h00);
    chk_out("R6 disp Y max", 24'h00203F, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
    issue(3'd3, 2'd2, 6'd32, 16'h0, 8'h5A);
    chk_out("R6 disp Z wrap", 24'h000010, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
    issue(3'd3, 2'd2, 6'd0, 16'h0, 8'h00);
    chk_out("R6 disp Z zero", 24'h00FFF0, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
  endtask

  task automatic t_direct;
    ptr_x_i = 16'hDEAD; ptr_y_i = 16'hBEEF; ptr_z_i = 16'hCAFE;
    issue(3'd4, 2'd0, 6'd5, 16'h4321, 8'h03);
    chk_out("R7 direct paged", 24'h034321, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
    issue(3'd4, 2'd2, 6'd0, 16'hFFFF, 8'h00);
    chk_out("R7 direct low", 24'h00FFFF, 1'b1, 1'b0, 16'h0, 2'd0, 1'b0);
  endtask

  task automatic t_illegal;
    ptr_x_i = 16'h1000;
    issue(3'd3, 2'd0, 6'd4, 16'h0, 8'h00);
    chk_out("R8 disp X", 24'h0, 1'b0, 1'b0, 16'h0, 2'd0, 1'b1);
    issue(3'd1, 2'd3, 6'd0, 16'h0, 8'h00);
    chk_out("R8 sel 3", 24'h0, 1'b0, 1'b0, 16'h0, 2'd0, 1'b1);
    for (int m = 5; m < 8; m++) begin
      issue(3'(m), 2'd1, 6'd0, 16'h1111, 8'h22);
      chk_out("R8 bad mode", 24'h0, 1'b0, 1'b0, 16'h0, 2'd0, 1'b1);
    end
  endtask

  task automatic t_idle;
    ptr_z_i = 16'h0040;
    issue(3'd1, 2'd2, 6'd0, 16'h0, 8'h00);
    chk_out("R9 pulse", 24'h00003F, 1'b1, 1'b1, 16'h003F, 2'd2, 1'b0);
    @(posedge clk);
    #1;
    chk_out("R9 drop", 24'h0, 1'b0, 1'b0, 16'h0, 2'd0, 1'b0);
    issue(3'd3, 2'd0, 6'd0, 16'h0, 8'h00);
    @(posedge clk);
    #1;
    chk("R9 illegal drop", 32'(illegal_o), 32'd0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_predec();
    t_postinc();
    t_wrap();
    t_disp();
    t_direct();
    t_illegal();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule